// File: doc/BRIEF.md
# Column-Parallel Matched Filter Bank

This block correlates one complex received sample vector against every column of a real-valued signature matrix. Each correlation is the sum, over the sample positions, of the received sample times the signature entry at that position. It gives one complex result per delay column. The matrix is split by column. Every processing lane owns a small signature memory for the columns it serves, a private copy of the received vector, and one multiply-accumulate datapath with separate real and imaginary accumulators. Lanes never read each other's storage, and there is no shared adder tree.

**Loading.** Signature entries are written one at a time by column and sample index. Received samples are written by sample index, and each write goes to all lane copies at once.

**Running.** A one-cycle start pulse launches all lanes together. Each lane takes one sample per cycle. When a lane serves several columns (the `SHARE` parameter), it finishes one column completely before it starts the next. A one-cycle done pulse marks the point where every result is final. The results then stay on the output buses until the next accepted start.

Top module: `col_mf_bank`

## Requirements

- R1: For every column c, `corr_re` for c equals the sum over k of rx_re[k]·sig[c][k], and `corr_im` for c equals the sum over k of rx_im[k]·sig[c][k]. All samples and entries are W-bit two's-complement values, and each result is an AW-bit two's-complement value.
- R2: AW = 2·W + clog2(N_SAMP). Sums stay exact at the extremes, for example every entry at -128 with every sample at -128 or at 127.
- R3: Column c is served by lane c mod LANES as its (c div LANES)-th job, where LANES = N_COL/SHARE. Its result sits at bits [c·AW +: AW] of each flat output bus, and all lanes run in lockstep.
- R4: `done` is a one-cycle pulse that goes high exactly SHARE·N_SAMP+1 clock edges after the edge that samples an accepted start.
- R5: `busy` rises on the edge after an accepted start and falls together with `done`. A start that arrives while `busy` is high is ignored: it neither extends the run nor causes a second `done`.
- R6: Signature and received-sample writes are ignored while `busy` is high.
- R7: After `done`, the results hold their values until the next accepted start, even if new loads take place in between.
- R8: After reset, `busy` and `done` are low and every correlation output is zero.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_we | input | 1 | Signature entry write strobe |
| sig_col | input | CW | Column index of the signature write |
| sig_idx | input | SW | Sample index of the signature write |
| sig_val | input | W | Signature entry value, signed |
| rx_we | input | 1 | Received sample write strobe, broadcast to all lanes |
| rx_idx | input | SW | Received sample index |
| rx_re | input | W | Received sample real part, signed |
| rx_im | input | W | Received sample imaginary part, signed |
| start | input | 1 | Start pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| corr_re | output | N_COL·AW | Real correlations, column c at [c·AW +: AW] |
| corr_im | output | N_COL·AW | Imaginary correlations, column c at [c·AW +: AW] |

## Verification

Random matrices and vectors from a fixed seed exercise the arithmetic. Extreme values set to -128 and 127 expose a truncated or unsigned accumulator. A sparse matrix puts a single nonzero entry in each column at a sample position that differs per column, with a per-column weight. Any swap of columns between lanes, between the sequential jobs inside a lane, or between output slots therefore shows up as a wrong value. Runs that inject a start pulse and memory writes in the middle of a run separate correct gating from a restarted or corrupted computation. Loads issued after completion confirm that the held results do not move.

// File: rtl/col_mf_bank.sv
module col_mf_bank #(
  parameter int W      = 8,
  parameter int N_SAMP = 16,
  parameter int N_COL  = 8,
  parameter int SHARE  = 2,
  localparam int LANES = N_COL / SHARE,
  localparam int SW    = (N_SAMP > 1) ? $clog2(N_SAMP) : 1,
  localparam int CW    = (N_COL > 1) ? $clog2(N_COL) : 1,
  localparam int AW    = 2 * W + $clog2(N_SAMP),
  localparam int DEPTH = SHARE * N_SAMP,
  localparam int DW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int UW    = (SHARE > 1) ? $clog2(SHARE) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sig_we,
  input  logic [CW-1:0]         sig_col,
  input  logic [SW-1:0]         sig_idx,
  input  logic signed [W-1:0]   sig_val,
  input  logic                  rx_we,
  input  logic [SW-1:0]         rx_idx,
  input  logic signed [W-1:0]   rx_re,
  input  logic signed [W-1:0]   rx_im,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  output logic [N_COL*AW-1:0]   corr_re,
  output logic [N_COL*AW-1:0]   corr_im
);

  logic             go;
  logic             load_ok;
  logic [31:0]      sig_lane;
  logic [DW-1:0]    sig_addr;
  logic [LANES-1:0] lane_end;
  logic [LANES-1:0] lane_act;

  assign go       = start && !busy;
  assign load_ok  = !busy;
  assign sig_lane = 32'(sig_col) % LANES;
  assign sig_addr = DW'((32'(sig_col) / LANES) * N_SAMP + 32'(sig_idx));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [W-1:0]  smem [DEPTH];
    logic signed [W-1:0]  rmem_re [N_SAMP];
    logic signed [W-1:0]  rmem_im [N_SAMP];
    logic                 run, v1, last1;
    logic [SW-1:0]        cnt;
    logic [UW-1:0]        sub, sub1;
    logic [DW-1:0]        rd_addr;
    logic signed [W-1:0]  s_q, re_q, im_q;
    logic signed [2*W-1:0] p_re, p_im;
    logic signed [AW-1:0] acc_re [SHARE];
    logic signed [AW-1:0] acc_im [SHARE];
    logic                 cnt_end, sub_end;

    assign rd_addr = DW'(32'(sub) * N_SAMP + 32'(cnt));
    assign cnt_end = (32'(cnt) == N_SAMP - 1);
    assign sub_end = (32'(sub) == SHARE - 1);
    assign p_re    = s_q * re_q;
    assign p_im    = s_q * im_q;
    assign lane_end[l] = v1 && last1;
    assign lane_act[l] = v1;

    always_ff @(posedge clk) begin
      if (load_ok && sig_we && sig_lane == l) smem[sig_addr] <= sig_val;
      if (load_ok && rx_we) begin
        rmem_re[rx_idx] <= rx_re;
        rmem_im[rx_idx] <= rx_im;
      end
      s_q  <= smem[rd_addr];
      re_q <= rmem_re[cnt];
      im_q <= rmem_im[cnt];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run   <= 1'b0;
        cnt   <= '0;
        sub   <= '0;
        v1    <= 1'b0;
        sub1  <= '0;
        last1 <= 1'b0;
      end else begin
        v1    <= run;
        sub1  <= sub;
        last1 <= run && cnt_end && sub_end;
        if (go) begin
          run <= 1'b1;
          cnt <= '0;
          sub <= '0;
        end else if (run) begin
          if (cnt_end) begin
            cnt <= '0;
            if (sub_end) run <= 1'b0;
            else sub <= sub + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || go) begin
        for (int s = 0; s < SHARE; s++) begin
          acc_re[s] <= '0;
          acc_im[s] <= '0;
        end
      end else if (v1) begin
        acc_re[sub1] <= acc_re[sub1] + AW'(p_re);
        acc_im[sub1] <= acc_im[sub1] + AW'(p_im);
      end
    end

    for (genvar s = 0; s < SHARE; s++) begin : g_out
      assign corr_re[(s*LANES+l)*AW +: AW] = acc_re[s];
      assign corr_im[(s*LANES+l)*AW +: AW] = acc_im[s];
    end

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (32'(cnt) < N_SAMP && 32'(sub) < SHARE));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= &lane_end;
      if (go) busy <= 1'b1;
      else if (&lane_end) busy <= 1'b0;
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(corr_re) && $stable(corr_im)));
  p_lanes_lockstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_act == '0) || (&lane_act));

endmodule

// File: tb/sim_col_mf_bank.sv
`timescale 1ns/1ps
module sim_col_mf_bank;
  localparam int W = 8, N_SAMP = 16, N_COL = 8, SHARE = 2;
  localparam int SW = $clog2(N_SAMP), CW = $clog2(N_COL);
  localparam int AW = 2 * W + $clog2(N_SAMP);
  localparam int T = SHARE * N_SAMP;

  logic clk = 0, rst_n = 0;
  logic sig_we = 0, rx_we = 0, start = 0;
  logic [CW-1:0] sig_col = '0;
  logic [SW-1:0] sig_idx = '0, rx_idx = '0;
  logic signed [W-1:0] sig_val = '0, rx_re = '0, rx_im = '0;
  logic busy, done;
  logic [N_COL*AW-1:0] corr_re, corr_im;

  int total = 0, bad = 0;
  logic signed [W-1:0] sig_m [N_COL][N_SAMP];
  logic signed [W-1:0] rxr_m [N_SAMP];
  logic signed [W-1:0] rxi_m [N_SAMP];
  longint snap_re [N_COL];
  longint snap_im [N_COL];

  always #4 clk = ~clk;

  col_mf_bank #(.W(W), .N_SAMP(N_SAMP), .N_COL(N_COL), .SHARE(SHARE)) u0 (
    .clk(clk), .rst_n(rst_n), .sig_we(sig_we), .sig_col(sig_col), .sig_idx(sig_idx),
    .sig_val(sig_val), .rx_we(rx_we), .rx_idx(rx_idx), .rx_re(rx_re), .rx_im(rx_im),
    .start(start), .busy(busy), .done(done), .corr_re(corr_re), .corr_im(corr_im));

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_re(input int c);
    longint s = 0;
    for (int k = 0; k < N_SAMP; k++) s += longint'(sig_m[c][k]) * longint'(rxr_m[k]);
    return s;
  endfunction

  function automatic longint exp_im(input int c);
    longint s = 0;
    for (int k = 0; k < N_SAMP; k++) s += longint'(sig_m[c][k]) * longint'(rxi_m[k]);
    return s;
  endfunction

  function automatic longint got_re(input int c);
    return longint'($signed(corr_re[c*AW +: AW]));
  endfunction

  function automatic longint got_im(input int c);
    return longint'($signed(corr_im[c*AW +: AW]));
  endfunction

  task automatic put_sig(input int c, input int k, input logic signed [W-1:0] v);
    @(negedge clk);
    sig_we = 1; sig_col = CW'(c); sig_idx = SW'(k); sig_val = v;
    @(negedge clk);
    sig_we = 0;
    sig_m[c][k] = v;
  endtask

  task automatic put_rx(input int k, input logic signed [W-1:0] r, input logic signed [W-1:0] i);
    @(negedge clk);
    rx_we = 1; rx_idx = SW'(k); rx_re = r; rx_im = i;
    @(negedge clk);
    rx_we = 0;
    rxr_m[k] = r; rxi_m[k] = i;
  endtask

  task automatic go(input bit poke, input bit wbusy);
    int n = 0, extra = 0;
    bit seen = 0, busy1 = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (!seen && n < T + 20) begin
      @(negedge clk);
      n++;
      if (n == 1) busy1 = busy;
      start = poke && (n == 5);
      if (wbusy && n == 7) begin
        sig_we = 1; sig_col = '0; sig_idx = '0; sig_val = 8'sd99;
        rx_we = 1; rx_idx = '0; rx_re = -8'sd77; rx_im = 8'sd55;
      end else begin
        sig_we = 0; rx_we = 0;
      end
      if (done) seen = 1;
    end
    start = 0; sig_we = 0; rx_we = 0;
    chk("R4 done latency", n, T + 1);
    chk("R5 busy high after start", busy1, 1);
    chk("R5 busy low with done", busy, 0);
    @(negedge clk);
    chk("R4 done one cycle", done, 0);
    if (poke) begin
      repeat (T + 4) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R5 ignored start no second done", extra, 0);
    end
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < N_COL; c++) begin
      chk({tag, " re"}, got_re(c), exp_re(c));
      chk({tag, " im"}, got_im(c), exp_im(c));
    end
  endtask

  task automatic load_random();
    for (int c = 0; c < N_COL; c++)
      for (int k = 0; k < N_SAMP; k++) put_sig(c, k, W'($urandom));
    for (int k = 0; k < N_SAMP; k++) put_rx(k, W'($urandom), W'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 busy after reset", busy, 0);
    chk("R8 done after reset", done, 0);
    for (int c = 0; c < N_COL; c++) begin
      chk("R8 re zero after reset", got_re(c), 0);
      chk("R8 im zero after reset", got_im(c), 0);
    end

    load_random();
    go(0, 0);
    check_all("R1 random");

    for (int c = 0; c < N_COL; c++)
      for (int k = 0; k < N_SAMP; k++) put_sig(c, k, -8'sd128);
    for (int k = 0; k < N_SAMP; k++) put_rx(k, -8'sd128, 8'sd127);
    go(0, 0);
    check_all("R2 extremes");
    chk("R2 max positive sum", got_re(N_COL - 1), longint'(N_SAMP) * 16384);

    for (int c = 0; c < N_COL; c++)
      for (int k = 0; k < N_SAMP; k++) put_sig(c, k, (k == (c * 3 + 1) % N_SAMP) ? W'(c + 1) : '0);
    for (int k = 0; k < N_SAMP; k++) put_rx(k, W'(k * 7 - 50), W'(60 - k * 5));
    go(0, 0);
    check_all("R3 column mapping");

    load_random();
    go(1, 0);
    check_all("R5 start during busy");

    go(0, 1);
    check_all("R6 writes during busy");
    go(0, 0);
    check_all("R6 memory untouched");

    for (int c = 0; c < N_COL; c++) begin
      snap_re[c] = exp_re(c);
      snap_im[c] = exp_im(c);
    end
    put_sig(0, 0, 8'sd17);
    put_rx(1, 8'sd3, -8'sd9);
    repeat (10) @(negedge clk);
    for (int c = 0; c < N_COL; c++) begin
      chk("R7 hold re", got_re(c), snap_re[c]);
      chk("R7 hold im", got_im(c), snap_im[c]);
    end

    for (int r = 0; r < 4; r++) begin
      load_random();
      go(0, 0);
      check_all("R1 random loop");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule